// File: doc/BRIEF.md
# UART Command Frame Decoder

This block sits behind a UART receiver (115200 baud) and inspects every 64-byte frame in the received byte stream. Most frames are ordinary work traffic for a hashing core. A few are control frames built on a fixed template: set bytes must hold given constants, most bytes must be zero, and a checksum byte ties the command and data bytes together. The block checks each byte as it arrives, so it never stores the frame. When a frame matches the template, the block takes out its command and data bytes and acts on them.

Command 0 loads a clock-multiplier register. The output frequency is that value × 2.5 MHz. Command 1 switches an identify LED on or off. A probe flag in the frame asks the block to answer with four zero bytes on a ready/valid transmit port. Every accepted control frame raises a one-cycle pulse, so the hashing core can restart its state. Every frame that does not match the template raises a one-cycle pass-through flag instead. The frame position returns to byte 0 after 64 bytes. It also returns to byte 0 when the line stays quiet for one frame time, so a stray byte cannot leave the decoder out of step.

Top module: `cmd_frame_decoder`

## Requirements
- R1: After reset, `clkMult` is 80, `identifyLed` is 0, and `txValid`, `cmdApplied` and `badFrame` are all 0.
- R2: A valid frame with command 0 and data in 20..84 loads `clkMult` with the data. The load happens at the clock edge that accepts byte 63, and `cmdApplied` is high for exactly the following cycle.
- R3: A valid command-0 frame whose data is below 20 or above 84 leaves `clkMult` unchanged, but `cmdApplied` still pulses.
- R4: A valid command-1 frame sets `identifyLed` to 1 when the data is 1 and to 0 when the data is 0. Any other data value leaves the LED unchanged.
- R5: A frame whose byte 32 is not 0xDA XOR byte 34 (command) XOR byte 33 (data) pulses `badFrame` for one cycle. It does not pulse `cmdApplied` and changes neither `clkMult` nor `identifyLed`.
- R6: The frame is also rejected with a `badFrame` pulse, as in R5, if any template byte is wrong. The template is: bytes 0–31, 36–51 and 62–63 are zero; byte 35 is 0xB7; bytes 52–55 are 0x62 0x66 0x67 0x30; bytes 56–59 are 0xFF; byte 60 is 0xB5; byte 61 is 0x00 or 0x01.
- R7: A valid frame with byte 61 = 0x01 (probe) queues a reply of exactly four bytes, each 0x00, on `txValid`/`txData`. A byte is consumed on each cycle where `txValid` and `txReady` are both high. While `txReady` is low, `txValid` stays high.
- R8: If a second valid probe frame completes while a reply is still pending, the remaining count is set back to four. It is not added to the bytes still pending.
- R9: If no byte arrives for IDLE_CYCLES consecutive cycles in the middle of a frame, the partial frame is dropped and the next byte is treated as byte 0. Shorter gaps do not break a frame.
- R10: After byte 63, the next byte is byte 0 of a new frame, so frames sent back to back are each decoded.
- R11: A valid frame with a command other than 0 or 1 pulses `cmdApplied` and changes neither `clkMult` nor `identifyLed`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Received byte present this cycle |
| inData | input | 8 | Received byte |
| txReady | input | 1 | Transmitter can take a reply byte |
| txValid | output | 1 | Reply byte offered |
| txData | output | 8 | Reply byte (always 0x00) |
| clkMult | output | 8 | Clock multiplier M; frequency = M × 2.5 MHz |
| identifyLed | output | 1 | Identify LED drive |
| cmdApplied | output | 1 | One-cycle pulse on an accepted control frame |
| badFrame | output | 1 | One-cycle pulse on a frame that fails the template |

## Verification
Two functions can act in the same cycle: a probe frame finishing and the draining of an earlier reply. The bench holds `txReady` low and sends two probe frames one after the other, so the second frame's reload meets a reply that has not moved. It then releases `txReady` and counts handshakes; the result must be exactly four, not eight. A related case checks that a reply stays offered while it is stalled, and that a probe frame whose command data is out of range leaves the multiplier unchanged while the reply still goes out.

// File: rtl/cfd_pkg.sv
package cfd_pkg;

  localparam int FRAME_BYTES = 64;
  localparam int IDX_W       = $clog2(FRAME_BYTES);

  // Positions the decoder depends on
  localparam int POS_CHK   = 32;
  localparam int POS_DATA  = 33;
  localparam int POS_CMD   = 34;
  localparam int POS_PROBE = 61;

  localparam logic [7:0] CHK_SEED = 8'hDA;

  localparam logic [7:0] CMD_MULT = 8'd0;
  localparam logic [7:0] CMD_LED  = 8'd1;

  // Strobes from framing control to datapath
  typedef struct packed {
    logic             take;   // byte accepted this cycle
    logic             last;   // accepted byte is the final one of the frame
    logic [IDX_W-1:0] idx;    // position of the accepted byte
  } frameStrobe_t;

  // {care, value}: care=0 means the byte is free (checksum, data, command, probe)
  function automatic logic [8:0] templateByte(input logic [IDX_W-1:0] idx);
    int i;
    i = int'(idx);
    if (i == POS_CHK || i == POS_DATA || i == POS_CMD || i == POS_PROBE)
      return 9'h000;
    else if (i == 35) return {1'b1, 8'hB7};
    else if (i == 52) return {1'b1, 8'h62};
    else if (i == 53) return {1'b1, 8'h66};
    else if (i == 54) return {1'b1, 8'h67};
    else if (i == 55) return {1'b1, 8'h30};
    else if (i >= 56 && i <= 59) return {1'b1, 8'hFF};
    else if (i == 60) return {1'b1, 8'hB5};
    else return {1'b1, 8'h00};
  endfunction

endpackage

// File: rtl/cfd_control.sv
module cfd_control
  import cfd_pkg::*;
#(
  parameter int IDLE_CYCLES = 1000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output frameStrobe_t strb
);

  localparam int IDLE_W = $clog2(IDLE_CYCLES + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);
  localparam logic [IDLE_W-1:0] IDLE_END = IDLE_W'(IDLE_CYCLES - 1);

  logic [IDX_W-1:0]  byteIdx;
  logic [IDLE_W-1:0] idleCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      byteIdx <= '0;
      idleCnt <= '0;
    end else if (inValid) begin
      idleCnt <= '0;
      byteIdx <= (byteIdx == LAST_IDX) ? '0 : byteIdx + 1'b1;
    end else if (byteIdx != '0) begin
      if (idleCnt == IDLE_END) begin
        byteIdx <= '0;
        idleCnt <= '0;
      end else begin
        idleCnt <= idleCnt + 1'b1;
      end
    end
  end

  always_comb begin
    strb.take = inValid;
    strb.last = inValid && (byteIdx == LAST_IDX);
    strb.idx  = byteIdx;
  end

  // R10: the frame position returns to 0 after the final byte
  a_r10_wrap: assert property (@(posedge clk) disable iff (!rstN)
    strb.last |=> (byteIdx == '0));

  // R9: a full idle window in mid-frame drops the partial frame
  a_r9_idle_drop: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid && byteIdx != '0 && idleCnt == IDLE_END) |=> (byteIdx == '0));

endmodule

// File: rtl/cfd_datapath.sv
module cfd_datapath
  import cfd_pkg::*;
#(
  parameter int MULT_W      = 8,
  parameter int MULT_MIN    = 20,
  parameter int MULT_MAX    = 84,
  parameter int MULT_RESET  = 80,
  parameter int REPLY_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  frameStrobe_t      strb,
  input  logic [7:0]        inData,
  input  logic              txReady,
  output logic              txValid,
  output logic [7:0]        txData,
  output logic [MULT_W-1:0] clkMult,
  output logic              identifyLed,
  output logic              cmdApplied,
  output logic              badFrame
);

  localparam int REPLY_W = $clog2(REPLY_BYTES + 1);

  logic              okAcc;
  logic [7:0]        chkReg, dataReg, cmdReg;
  logic              probeReg;
  logic [REPLY_W-1:0] replyLeft;

  logic [8:0] tmpl;
  logic       byteOk, runOk, frameGood, replyLoad;

  // Per-byte template check, done as the byte streams past
  always_comb begin
    tmpl = templateByte(strb.idx);
    if (int'(strb.idx) == POS_PROBE)
      byteOk = (inData[7:1] == 7'd0);
    else if (tmpl[8])
      byteOk = (inData == tmpl[7:0]);
    else
      byteOk = 1'b1;
    runOk     = (strb.idx == '0) ? byteOk : (okAcc && byteOk);
    frameGood = runOk && (chkReg == (CHK_SEED ^ dataReg ^ cmdReg));
    replyLoad = strb.last && frameGood && probeReg;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      okAcc    <= 1'b0;
      chkReg   <= '0;
      dataReg  <= '0;
      cmdReg   <= '0;
      probeReg <= 1'b0;
    end else if (strb.take) begin
      okAcc <= runOk;
      if (int'(strb.idx) == POS_CHK)   chkReg   <= inData;
      if (int'(strb.idx) == POS_DATA)  dataReg  <= inData;
      if (int'(strb.idx) == POS_CMD)   cmdReg   <= inData;
      if (int'(strb.idx) == POS_PROBE) probeReg <= inData[0];
    end
  end

  // Command execution at the final byte
  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkMult     <= MULT_W'(MULT_RESET);
      identifyLed <= 1'b0;
      cmdApplied  <= 1'b0;
      badFrame    <= 1'b0;
    end else if (strb.last) begin
      cmdApplied <= frameGood;
      badFrame   <= !frameGood;
      if (frameGood) begin
        if (cmdReg == CMD_MULT) begin
          if (dataReg >= 8'(MULT_MIN) && dataReg <= 8'(MULT_MAX))
            clkMult <= MULT_W'(dataReg);
        end else if (cmdReg == CMD_LED) begin
          if (dataReg == 8'd1)      identifyLed <= 1'b1;
          else if (dataReg == 8'd0) identifyLed <= 1'b0;
        end
      end
    end else begin
      cmdApplied <= 1'b0;
      badFrame   <= 1'b0;
    end
  end

  // Probe reply: a reload wins over a handshake in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN)
      replyLeft <= '0;
    else if (replyLoad)
      replyLeft <= REPLY_W'(REPLY_BYTES);
    else if (txValid && txReady)
      replyLeft <= replyLeft - 1'b1;
  end

  assign txValid = (replyLeft != '0);
  assign txData  = 8'h00;

  // R2: the apply pulse lasts one cycle
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    cmdApplied |=> !cmdApplied);

  // R5: accept and reject never coincide
  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdApplied && badFrame));

  // R3: multiplier stays in its legal window
  a_r3_mult_range: assert property (@(posedge clk) disable iff (!rstN)
    (clkMult >= MULT_W'(MULT_MIN)) && (clkMult <= MULT_W'(MULT_MAX)));

  // R3: multiplier only moves with an accepted frame
  a_r3_mult_on_apply: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(clkMult) |-> cmdApplied);

  // R4: LED only moves with an accepted frame
  a_r4_led_on_apply: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(identifyLed) |-> cmdApplied);

  // R7: a stalled reply stays offered
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> txValid);

endmodule

// File: rtl/cmd_frame_decoder.sv
module cmd_frame_decoder
  import cfd_pkg::*;
#(
  parameter int CLK_HZ      = 125_000_000,
  parameter int BAUD        = 115_200,
  parameter int IDLE_CYCLES = (CLK_HZ / BAUD) * 10 * FRAME_BYTES,
  parameter int MULT_MIN    = 20,
  parameter int MULT_MAX    = 84,
  parameter int MULT_RESET  = 80
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [7:0] inData,
  input  logic       txReady,
  output logic       txValid,
  output logic [7:0] txData,
  output logic [7:0] clkMult,
  output logic       identifyLed,
  output logic       cmdApplied,
  output logic       badFrame
);

  frameStrobe_t frameStrb;

  cfd_control #(
    .IDLE_CYCLES(IDLE_CYCLES)
  ) u_control (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .strb    (frameStrb)
  );

  cfd_datapath #(
    .MULT_W     (8),
    .MULT_MIN   (MULT_MIN),
    .MULT_MAX   (MULT_MAX),
    .MULT_RESET (MULT_RESET),
    .REPLY_BYTES(4)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (frameStrb),
    .inData      (inData),
    .txReady     (txReady),
    .txValid     (txValid),
    .txData      (txData),
    .clkMult     (clkMult),
    .identifyLed (identifyLed),
    .cmdApplied  (cmdApplied),
    .badFrame    (badFrame)
  );

endmodule

// File: tb/cmd_frame_decoder_bench.sv
module cmd_frame_decoder_bench;

  localparam int IDLE = 200;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] inData = 8'h00;
  logic       txReady = 1'b1;
  logic       txValid;
  logic [7:0] txData;
  logic [7:0] clkMult;
  logic       identifyLed, cmdApplied, badFrame;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cmd_frame_decoder #(.IDLE_CYCLES(IDLE)) u_cmd_frame_decoder (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .txReady(txReady), .txValid(txValid), .txData(txData),
    .clkMult(clkMult), .identifyLed(identifyLed),
    .cmdApplied(cmdApplied), .badFrame(badFrame)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk);
    inValid = 1'b1;
    inData  = b;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  // corruptIdx < 0: no corruption; gapAt < 0: no pause
  task automatic sendFrame(input logic [7:0] cmd, input logic [7:0] data, input bit probe,
                           input int corruptIdx, input logic [7:0] corruptXor,
                           input int gapAt, input int gapLen);
    logic [7:0] f [64];
    for (int i = 0; i < 64; i++) f[i] = 8'h00;
    f[32] = 8'hDA ^ cmd ^ data;
    f[33] = data;
    f[34] = cmd;
    f[35] = 8'hB7;
    f[52] = 8'h62; f[53] = 8'h66; f[54] = 8'h67; f[55] = 8'h30;
    for (int i = 56; i < 60; i++) f[i] = 8'hFF;
    f[60] = 8'hB5;
    f[61] = probe ? 8'h01 : 8'h00;
    if (corruptIdx >= 0) f[corruptIdx] = f[corruptIdx] ^ corruptXor;
    for (int i = 0; i < 64; i++) begin
      if (i == gapAt) repeat (gapLen) @(negedge clk);
      sendByte(f[i]);
    end
  endtask

  task automatic testReset();
    check(clkMult == 8'd80, "R1 clkMult", clkMult, 80);
    check(identifyLed == 1'b0, "R1 led", identifyLed, 0);
    check(txValid == 1'b0, "R1 txValid", txValid, 0);
    check(cmdApplied == 1'b0 && badFrame == 1'b0, "R1 pulses", {cmdApplied, badFrame}, 0);
  endtask

  task automatic testSetMult();
    sendFrame(8'd0, 8'd40, 0, -1, 0, -1, 0);
    check(cmdApplied == 1'b1, "R2 applied pulse", cmdApplied, 1);
    check(clkMult == 8'd40, "R2 mult 40", clkMult, 40);
    check(badFrame == 1'b0, "R2 no bad", badFrame, 0);
    @(negedge clk);
    check(cmdApplied == 1'b0, "R2 pulse one cycle", cmdApplied, 0);
    sendFrame(8'd0, 8'd20, 0, -1, 0, -1, 0);
    check(clkMult == 8'd20, "R2 mult min 20", clkMult, 20);
    sendFrame(8'd0, 8'd84, 0, -1, 0, -1, 0);
    check(clkMult == 8'd84, "R2 mult max 84", clkMult, 84);
  endtask

  task automatic testOutOfRange();
    sendFrame(8'd0, 8'd19, 0, -1, 0, -1, 0);
    check(clkMult == 8'd84, "R3 data 19 ignored", clkMult, 84);
    check(cmdApplied == 1'b1, "R3 pulse on 19", cmdApplied, 1);
    sendFrame(8'd0, 8'd85, 0, -1, 0, -1, 0);
    check(clkMult == 8'd84, "R3 data 85 ignored", clkMult, 84);
  endtask

  task automatic testLed();
    sendFrame(8'd1, 8'd1, 0, -1, 0, -1, 0);
    check(identifyLed == 1'b1, "R4 led on", identifyLed, 1);
    sendFrame(8'd1, 8'd7, 0, -1, 0, -1, 0);
    check(identifyLed == 1'b1, "R4 data 7 no effect", identifyLed, 1);
    check(clkMult == 8'd84, "R4 mult untouched", clkMult, 84);
    sendFrame(8'd1, 8'd0, 0, -1, 0, -1, 0);
    check(identifyLed == 1'b0, "R4 led off", identifyLed, 0);
  endtask

  task automatic testBadChk();
    sendFrame(8'd0, 8'd30, 0, 32, 8'h01, -1, 0);
    check(badFrame == 1'b1, "R5 bad flag", badFrame, 1);
    check(cmdApplied == 1'b0, "R5 no apply", cmdApplied, 0);
    check(clkMult == 8'd84, "R5 mult kept", clkMult, 84);
    @(negedge clk);
    check(badFrame == 1'b0, "R5 flag one cycle", badFrame, 0);
  endtask

  task automatic testBadSig();
    sendFrame(8'd0, 8'd30, 0, 53, 8'h01, -1, 0);
    check(badFrame == 1'b1 && clkMult == 8'd84, "R6 signature byte", clkMult, 84);
    sendFrame(8'd0, 8'd30, 0, 5, 8'h10, -1, 0);
    check(badFrame == 1'b1 && clkMult == 8'd84, "R6 zero byte", clkMult, 84);
    sendFrame(8'd0, 8'd30, 0, 61, 8'h02, -1, 0);
    check(badFrame == 1'b1 && clkMult == 8'd84, "R6 probe byte 2", clkMult, 84);
    sendFrame(8'd0, 8'd30, 0, 63, 8'h80, -1, 0);
    check(badFrame == 1'b1 && cmdApplied == 1'b0, "R6 last byte", badFrame, 1);
  endtask

  task automatic countReply(input string req, input int expCount);
    int n = 0;
    bit dataOk = 1;
    txReady = 1'b1;
    for (int c = 0; c < 12; c++) begin
      if (txValid && txReady) begin
        n++;
        if (txData != 8'h00) dataOk = 0;
      end
      @(negedge clk);
    end
    check(n == expCount, req, n, expCount);
    check(dataOk, {req, " zero data"}, dataOk, 1);
  endtask

  task automatic testProbe();
    txReady = 1'b0;
    sendFrame(8'd0, 8'd1, 1, -1, 0, -1, 0);
    check(txValid == 1'b1, "R7 reply offered", txValid, 1);
    check(clkMult == 8'd84, "R7 probe data 1 ignored", clkMult, 84);
    repeat (3) @(negedge clk);
    check(txValid == 1'b1, "R7 held while stalled", txValid, 1);
    countReply("R7 reply count", 4);
    check(txValid == 1'b0, "R7 reply done", txValid, 0);
  endtask

  task automatic testOverlap();
    txReady = 1'b0;
    sendFrame(8'd0, 8'd1, 1, -1, 0, -1, 0);
    sendFrame(8'd0, 8'd1, 1, -1, 0, -1, 0);
    countReply("R8 reload not add", 4);
  endtask

  task automatic testTimeout();
    for (int i = 0; i < 10; i++) sendByte(8'h00);
    repeat (IDLE + 5) @(negedge clk);
    sendFrame(8'd0, 8'd50, 0, -1, 0, -1, 0);
    check(cmdApplied == 1'b1 && clkMult == 8'd50, "R9 resync after idle", clkMult, 50);
    sendFrame(8'd0, 8'd60, 0, -1, 0, 20, IDLE / 2);
    check(cmdApplied == 1'b1 && clkMult == 8'd60, "R9 short gap kept", clkMult, 60);
  endtask

  task automatic testBackToBack();
    sendFrame(8'd0, 8'd70, 0, -1, 0, -1, 0);
    check(clkMult == 8'd70, "R10 first frame", clkMult, 70);
    sendFrame(8'd0, 8'd71, 0, -1, 0, -1, 0);
    check(clkMult == 8'd71 && cmdApplied == 1'b1, "R10 second frame", clkMult, 71);
  endtask

  task automatic testUnknown();
    sendFrame(8'd5, 8'd9, 0, -1, 0, -1, 0);
    check(cmdApplied == 1'b1, "R11 pulse", cmdApplied, 1);
    check(clkMult == 8'd71 && identifyLed == 1'b0, "R11 no change", clkMult, 71);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSetMult();
    testOutOfRange();
    testLed();
    testBadChk();
    testBadSig();
    testProbe();
    testOverlap();
    testTimeout();
    testBackToBack();
    testUnknown();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule